// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block produces the elementary time slots of an open-drain single-wire bus: a reset pulse with presence detection, a write-zero slot, a write-one slot and a read slot. A controller hands it one slot operation at a time over a valid/ready handshake, together with a speed bit. The speed bit picks the regular or the overdrive timing profile for that operation alone. All durations are counted in ticks of a one-microsecond enable input and are held in parameters.

The engine drives the bus through a single drive-low enable. An external open-drain pad or pull-up network turns that enable into the wire level. The wire is read back through a two-flop synchronizer, and the synchronized level is also brought out. A read slot returns the sampled bit. A reset returns one of three presence outcomes: a device answered, no device answered, or the line was already low before the reset began. Each completed operation, recovery time included, ends in a one-cycle done strobe.

Top module: `owire_slot_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until the cycle in which `done` is high. `done` is a one-cycle pulse, and `cmd_ready` rises in that same cycle.
- R2: `cmd_op` encodes 00 = reset with presence, 01 = write-zero, 10 = write-one, 11 = read. `cmd_speed` 0 selects the regular profile and 1 selects the overdrive profile.
- R3: A write-zero holds `drive_low` for 60 ticks in a 60-tick slot at regular speed. At overdrive it holds `drive_low` for 6 ticks in an 11-tick slot.
- R4: A write-one holds `drive_low` for 1 tick at either speed and releases it for the rest of the slot (60 ticks regular, 11 overdrive).
- R5: A read holds `drive_low` for 1 tick and samples the synchronized line on the tick at which 15 (regular) or 2 (overdrive) ticks of the slot have elapsed. The sampled bit appears on `rd_bit` with `done`. `rd_bit` keeps its value until the next read completes.
- R6: A reset holds `drive_low` for 480 ticks and then releases the bus for 480 ticks at regular speed. At overdrive both phases are 48 ticks.
- R7: After a reset, `presence` reads 00 if the synchronized line was low on any tick from 15 to 119 ticks after release (2 to 13 at overdrive). Otherwise it reads 01. `presence` changes only when a reset completes.
- R8: If the synchronized line is low in the cycle a reset is accepted, the bus is not driven, `presence` becomes 10, and `done` follows after the recovery time.
- R9: Every operation is followed by 1 tick of recovery with the bus released. The number of ticks with `cmd_ready` low equals the slot length plus the recovery.
- R10: Durations depend only on the number of `tick_us` pulses, not on how many clock cycles separate them.
- R11: `bus_in` reaches `line_sync` through exactly two flops. `line_sync` resets to 1.
- R12: After reset: `cmd_ready` = 1, `drive_low` = 0, `done` = 0, `rd_bit` = 0, `presence` = 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable every microsecond |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Slot operation code |
| cmd_speed | input | 1 | 0 regular, 1 overdrive |
| done | output | 1 | Operation finished (one cycle) |
| rd_bit | output | 1 | Last bit read |
| presence | output | 2 | Last reset outcome |
| bus_in | input | 1 | Raw wire level |
| drive_low | output | 1 | Pull the wire low when high |
| line_sync | output | 1 | Synchronized wire level |

## Verification
The assertions assume that the controller changes `cmd_valid` and `cmd_op` only between clock edges and never expects a second acceptance before `done`. They also assume `bus_in` comes from a wired-AND of the engine's own drive and the devices. The bench builds that wired-AND from `drive_low` and its own device model. It issues every command only once `cmd_ready` is seen high and drops `cmd_valid` right after acceptance. The device model pulls the line only inside a slot or after a reset release, except in the deliberate short-circuit case.

// File: rtl/owire_slot_pkg.sv
package owire_slot_pkg;

    localparam int TW = 16;

    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_WRITE0 = 2'b01,
        OP_WRITE1 = 2'b10,
        OP_READ   = 2'b11
    } slot_op_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'b00,
        PH_SLOT    = 2'b01,
        PH_RECOVER = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        PRES_FOUND = 2'b00,
        PRES_NONE  = 2'b01,
        PRES_SHORT = 2'b10
    } pres_e;

    // One speed profile, all values in microsecond ticks.
    typedef struct packed {
        logic [TW-1:0] slot;
        logic [TW-1:0] low0;
        logic [TW-1:0] low1;
        logic [TW-1:0] lowr;
        logic [TW-1:0] rdv;
        logic [TW-1:0] rstl;
        logic [TW-1:0] rsth;
        logic [TW-1:0] pd_from;
        logic [TW-1:0] pd_to;
        logic [TW-1:0] rec;
    } speed_set_t;

    // Timing of one concrete operation, counted from slot start.
    typedef struct packed {
        logic [TW-1:0] low_len;
        logic [TW-1:0] slot_len;
        logic [TW-1:0] sample_at;
        logic [TW-1:0] win_from;
        logic [TW-1:0] win_to;
        logic [TW-1:0] rec_len;
    } slot_plan_t;

    function automatic slot_plan_t build_plan(speed_set_t s, slot_op_e op);
        slot_plan_t p;
        p.rec_len   = s.rec;
        p.sample_at = s.rdv;
        p.win_from  = s.rstl + s.pd_from;
        p.win_to    = s.rstl + s.pd_to;
        p.slot_len  = s.slot;
        unique case (op)
            OP_RESET: begin
                p.low_len  = s.rstl;
                p.slot_len = s.rstl + s.rsth;
            end
            OP_WRITE0: p.low_len = s.low0;
            OP_WRITE1: p.low_len = s.low1;
            default:   p.low_len = s.lowr;
        endcase
        return p;
    endfunction

    function automatic pres_e grade_presence(logic shorted, logic seen);
        if (shorted)
            return PRES_SHORT;
        return seen ? PRES_FOUND : PRES_NONE;
    endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/owire_profile.sv
module owire_profile
    import owire_slot_pkg::*;
#(
    parameter int REG_SLOT    = 60,
    parameter int REG_LOW0    = 60,
    parameter int REG_LOW1    = 1,
    parameter int REG_LOWR    = 1,
    parameter int REG_RDV     = 15,
    parameter int REG_RSTL    = 480,
    parameter int REG_RSTH    = 480,
    parameter int REG_PD_FROM = 15,
    parameter int REG_PD_TO   = 120,
    parameter int REG_REC     = 1,
    parameter int OD_SLOT     = 11,
    parameter int OD_LOW0     = 6,
    parameter int OD_LOW1     = 1,
    parameter int OD_LOWR     = 1,
    parameter int OD_RDV      = 2,
    parameter int OD_RSTL     = 48,
    parameter int OD_RSTH     = 48,
    parameter int OD_PD_FROM  = 2,
    parameter int OD_PD_TO    = 14,
    parameter int OD_REC      = 1
) (
    input  logic       speed,
    input  slot_op_e   op,
    output slot_plan_t plan
);
    localparam int NSPEED = 2;
    localparam int NOP    = 4;

    localparam speed_set_t REG_SET = '{
        slot: TW'(REG_SLOT), low0: TW'(REG_LOW0), low1: TW'(REG_LOW1),
        lowr: TW'(REG_LOWR), rdv: TW'(REG_RDV), rstl: TW'(REG_RSTL),
        rsth: TW'(REG_RSTH), pd_from: TW'(REG_PD_FROM),
        pd_to: TW'(REG_PD_TO), rec: TW'(REG_REC)};

    localparam speed_set_t OD_SET = '{
        slot: TW'(OD_SLOT), low0: TW'(OD_LOW0), low1: TW'(OD_LOW1),
        lowr: TW'(OD_LOWR), rdv: TW'(OD_RDV), rstl: TW'(OD_RSTL),
        rsth: TW'(OD_RSTH), pd_from: TW'(OD_PD_FROM),
        pd_to: TW'(OD_PD_TO), rec: TW'(OD_REC)};

    slot_plan_t tab [NSPEED][NOP];

    for (genvar s = 0; s < NSPEED; s++) begin : g_speed
        localparam speed_set_t SET = (s == 0) ? REG_SET : OD_SET;
        for (genvar o = 0; o < NOP; o++) begin : g_op
            assign tab[s][o] = build_plan(SET, slot_op_e'(o));
        end
    end

    assign plan = tab[speed][op];
endmodule

// File: rtl/owire_sequencer.sv
module owire_sequencer
    import owire_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_speed,
    input  logic       line_s,
    input  slot_plan_t plan,
    output slot_op_e   op_q,
    output logic       speed_q,
    output logic       ready,
    output logic       done,
    output logic       drive_low,
    output logic       rd_bit,
    output logic [1:0] presence
);
    phase_e        phase;
    logic [TW-1:0] cnt;
    logic          shorted;
    logic          seen;
    logic          sampled;
    logic          last_tick;
    logic          in_window;

    assign ready     = (phase == PH_IDLE);
    assign drive_low = (phase == PH_SLOT) && (cnt < plan.low_len);
    assign in_window = (cnt >= plan.win_from) && (cnt < plan.win_to);
    assign last_tick = (phase == PH_SLOT)
                     ? (cnt == plan.slot_len - TW'(1))
                     : (cnt == plan.rec_len - TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            op_q     <= OP_RESET;
            speed_q  <= 1'b0;
            shorted  <= 1'b0;
            seen     <= 1'b0;
            sampled  <= 1'b0;
            done     <= 1'b0;
            rd_bit   <= 1'b0;
            presence <= PRES_NONE;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= slot_op_e'(cmd_op);
                        speed_q <= cmd_speed;
                        cnt     <= '0;
                        seen    <= 1'b0;
                        if (slot_op_e'(cmd_op) == OP_RESET && !line_s) begin
                            shorted <= 1'b1;
                            phase   <= PH_RECOVER;
                        end else begin
                            shorted <= 1'b0;
                            phase   <= PH_SLOT;
                        end
                    end
                end
                PH_SLOT: begin
                    if (tick) begin
                        if (op_q == OP_READ && cnt == plan.sample_at)
                            sampled <= line_s;
                        if (op_q == OP_RESET && in_window && !line_s)
                            seen <= 1'b1;
                        if (last_tick) begin
                            cnt   <= '0;
                            phase <= PH_RECOVER;
                        end else begin
                            cnt <= cnt + TW'(1);
                        end
                    end
                end
                PH_RECOVER: begin
                    if (tick) begin
                        if (last_tick) begin
                            cnt   <= '0;
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            if (op_q == OP_READ)
                                rd_bit <= sampled;
                            if (op_q == OP_RESET)
                                presence <= grade_presence(shorted, seen);
                        end else begin
                            cnt <= cnt + TW'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
    import owire_slot_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_SLOT    = 60,
    parameter int REG_LOW0    = 60,
    parameter int REG_LOW1    = 1,
    parameter int REG_LOWR    = 1,
    parameter int REG_RDV     = 15,
    parameter int REG_RSTL    = 480,
    parameter int REG_RSTH    = 480,
    parameter int REG_PD_FROM = 15,
    parameter int REG_PD_TO   = 120,
    parameter int REG_REC     = 1,
    parameter int OD_SLOT     = 11,
    parameter int OD_LOW0     = 6,
    parameter int OD_LOW1     = 1,
    parameter int OD_LOWR     = 1,
    parameter int OD_RDV      = 2,
    parameter int OD_RSTL     = 48,
    parameter int OD_RSTH     = 48,
    parameter int OD_PD_FROM  = 2,
    parameter int OD_PD_TO    = 14,
    parameter int OD_REC      = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_speed,
    output logic       done,
    output logic       rd_bit,
    output logic [1:0] presence,
    input  logic       bus_in,
    output logic       drive_low,
    output logic       line_sync
);
    slot_op_e   op_q;
    logic       speed_q;
    slot_plan_t plan;

    owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (line_sync)
    );

    owire_profile #(
        .REG_SLOT(REG_SLOT), .REG_LOW0(REG_LOW0), .REG_LOW1(REG_LOW1),
        .REG_LOWR(REG_LOWR), .REG_RDV(REG_RDV), .REG_RSTL(REG_RSTL),
        .REG_RSTH(REG_RSTH), .REG_PD_FROM(REG_PD_FROM),
        .REG_PD_TO(REG_PD_TO), .REG_REC(REG_REC),
        .OD_SLOT(OD_SLOT), .OD_LOW0(OD_LOW0), .OD_LOW1(OD_LOW1),
        .OD_LOWR(OD_LOWR), .OD_RDV(OD_RDV), .OD_RSTL(OD_RSTL),
        .OD_RSTH(OD_RSTH), .OD_PD_FROM(OD_PD_FROM),
        .OD_PD_TO(OD_PD_TO), .OD_REC(OD_REC)
    ) u_profile (
        .speed (speed_q),
        .op    (op_q),
        .plan  (plan)
    );

    owire_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_us),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_speed (cmd_speed),
        .line_s    (line_sync),
        .plan      (plan),
        .op_q      (op_q),
        .speed_q   (speed_q),
        .ready     (cmd_ready),
        .done      (done),
        .drive_low (drive_low),
        .rd_bit    (rd_bit),
        .presence  (presence)
    );
endmodule

// File: rtl/owire_slot_checks.sv
module owire_slot_checks (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       done,
    input logic       drive_low,
    input logic       rd_bit,
    input logic [1:0] presence,
    input logic       bus_in,
    input logic       line_sync
);
    // R1: an accepted command takes the engine out of idle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R1: done lasts one cycle
    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: ready returns only together with done
    a_r1_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_ready) |-> done);

    // R1: never driving while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !drive_low);

    // R9: releasing the bus is followed by recovery, not idle
    a_r9_recovery_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_low) |-> !cmd_ready);

    // R5: read result only moves with done
    a_r5_rd_bit_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_bit));

    // R7: presence only moves with done
    a_r7_presence_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(presence));

    // R8: presence takes only the three defined codes
    a_r8_presence_code: assert property (@(posedge clk) disable iff (rst)
        presence != 2'b11);

    // R11: two-flop latency from the wire
    a_r11_sync_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) && !$past(rst, 3) |-> line_sync == $past(bus_in, 2));
endmodule

bind owire_slot_engine owire_slot_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .drive_low (drive_low),
    .rd_bit    (rd_bit),
    .presence  (presence),
    .bus_in    (bus_in),
    .line_sync (line_sync)
);

// File: tb/owire_slot_engine_tb.sv
module owire_slot_engine_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_speed = 1'b0;
    logic       done;
    logic       rd_bit;
    logic [1:0] presence;
    logic       bus_in;
    logic       drive_low;
    logic       line_sync;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    // device side of the wire
    logic hold_low = 1'b0;
    logic slave_pull = 1'b0;
    assign bus_in = !(drive_low || hold_low || slave_pull);

    owire_slot_engine u_dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_speed(cmd_speed),
        .done(done), .rd_bit(rd_bit), .presence(presence), .bus_in(bus_in),
        .drive_low(drive_low), .line_sync(line_sync)
    );

    // microsecond tick generator
    int tick_period = 4;
    int tick_div = 0;
    always @(posedge clk) begin
        if (tick_div >= tick_period - 1) begin
            tick_div <= 0;
            tick_us  <= 1'b1;
        end else begin
            tick_div <= tick_div + 1;
            tick_us  <= 1'b0;
        end
    end

    // presence pulse model, timed from the release of a reset
    logic pres_armed = 1'b0;
    int   pres_dly = 0;
    int   pres_len = 0;
    int   rel = 0;
    logic rel_run = 1'b0;
    logic dl_prev = 1'b0;
    always @(posedge clk) begin
        dl_prev <= drive_low;
        if (!pres_armed) begin
            rel_run    <= 1'b0;
            rel        <= 0;
            slave_pull <= 1'b0;
        end else begin
            if (dl_prev && !drive_low) begin
                rel_run <= 1'b1;
                rel     <= 0;
            end else if (rel_run && tick_us) begin
                rel <= rel + 1;
            end
            slave_pull <= rel_run && (rel >= pres_dly) && (rel < pres_dly + pres_len);
        end
    end

    typedef struct {
        int    low;
        int    busy;
        int    rd;
        int    pres;
        string tag;
    } exp_t;
    exp_t q[$];

    int exp_rd   = 0;
    int exp_pres = 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    int low_cnt = 0;
    int busy_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (tick_us && drive_low) low_cnt++;
            if (tick_us && !cmd_ready) busy_cnt++;
            if (done) begin
                if (q.size() == 0) begin
                    check("R1 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " low ticks"}, low_cnt, e.low);
                    check("R9 busy ticks", busy_cnt, e.busy);
                    check("R5 rd_bit", int'(rd_bit), e.rd);
                    check("R7 presence", int'(presence), e.pres);
                    check("R1 ready with done", int'(cmd_ready), 1);
                end
                low_cnt  = 0;
                busy_cnt = 0;
            end
        end
    end

    // driver: push the expectation, then hand over the command
    task automatic run_op(input int op, input int spd, input int low,
                          input int busy, input string tag);
        exp_t e;
        e.low = low; e.busy = busy; e.rd = exp_rd; e.pres = exp_pres; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_speed = 1'(spd);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1 ready low after accept", int'(cmd_ready), 0);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input int spd, input int bitval, input int slot, input string tag);
        hold_low = (bitval == 0);
        exp_rd = bitval;
        run_op(3, spd, 1, slot + 1, tag);
        hold_low = 1'b0;
    endtask

    task automatic do_reset(input int spd, input int dly, input int len,
                            input int expect_pres, input int half, input string tag);
        pres_dly = dly;
        pres_len = len;
        pres_armed = (len > 0);
        exp_pres = expect_pres;
        run_op(0, spd, half, 2 * half + 1, tag);
        pres_armed = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 ready", int'(cmd_ready), 1);
        check("R12 drive_low", int'(drive_low), 0);
        check("R12 done", int'(done), 0);
        check("R12 rd_bit", int'(rd_bit), 0);
        check("R12 presence", int'(presence), 1);
        check("R11 line_sync reset", int'(line_sync), 1);

        // R11 two-flop latency
        hold_low = 1'b1;
        @(negedge clk);
        check("R11 after one edge", int'(line_sync), 1);
        @(negedge clk);
        check("R11 after two edges", int'(line_sync), 0);
        hold_low = 1'b0;
        repeat (3) @(negedge clk);

        // regular speed slots (R2 encodings, R3 R4 R5)
        run_op(1, 0, 60, 61, "R3 write-zero regular");
        run_op(2, 0, 1, 61, "R4 write-one regular");
        do_read(0, 0, 60, "R5 read0 regular");
        do_read(0, 1, 60, "R5 read1 regular");
        run_op(1, 0, 60, 61, "R5 rd_bit holds over write");

        // resets (R6 R7 R8)
        do_reset(0, 0, 0, 1, 480, "R6 reset no device");
        do_reset(0, 15, 60, 0, 480, "R7 early short pulse");
        do_reset(0, 60, 240, 0, 480, "R7 late long pulse");
        do_reset(0, 130, 100, 1, 480, "R7 pulse outside window");
        hold_low = 1'b1;
        repeat (3) @(negedge clk);
        exp_pres = 2;
        run_op(0, 0, 0, 1, "R8 shorted line");
        hold_low = 1'b0;
        repeat (3) @(negedge clk);

        // overdrive (R3 R4 R5 R6 R7)
        run_op(1, 1, 6, 12, "R3 write-zero overdrive");
        run_op(2, 1, 1, 12, "R4 write-one overdrive");
        do_read(1, 0, 11, "R5 read0 overdrive");
        do_read(1, 1, 11, "R5 read1 overdrive");
        do_reset(1, 0, 0, 1, 48, "R6 reset overdrive");
        do_reset(1, 3, 8, 0, 48, "R7 presence overdrive");

        // R10 slower tick spacing
        tick_period = 7;
        run_op(2, 0, 1, 61, "R10 write-one slow tick");
        do_read(1, 0, 11, "R10 read0 slow tick");
        run_op(1, 1, 6, 12, "R10 write-zero slow tick");

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule